// File: doc/BRIEF.md
# In-Array Row Copy Memory Bank Model

A synthesizable behavioural model of a small DRAM-like store. Storage is split into banks. Each bank is split into subarrays, and each subarray has its own row buffer. Commands use DRAM terms: open a row, close a bank, read a word, write a word, and move one cache line between banks. Each command carries bank, subarray, row and column fields, and read data comes back on a narrow one-word port. The model can copy rows in two ways. The first copies a whole row inside a subarray by passing it through the row buffer. The second copies one cache line at a time over a shared internal bus, with the fetch and store stages overlapped.

The main effect is in-array copy. Open a row, then open another row of the same subarray without closing the bank first. The open row buffer is then written in full into the new row, and the new row becomes the open row. In every subarray, row 0 is a reserved row that always reads as zeros. Copying from it clears a row in a single command.

The default geometry is 2 banks, 2 subarrays per bank, 8 rows per subarray, 8 columns per row and 8-bit words. A cache line is 4 words. Refresh, analog sensing, timing-parameter checks and a real device pin protocol are not modelled.

Top module: `rowcopy_top`

## Requirements
- R1: After a synchronous active-low reset, `rdValid`, `cmdError` and `busy` are 0 and every storage cell reads as zero. Command codes are: 0 idle, 1 open row, 2 close bank, 3 read, 4 write, 5 line transfer. Codes 6 and 7 act as idle.
- R2: An open-row command (code 1) on a closed bank loads the addressed row into the subarray's row buffer. A read (code 3) of the open subarray returns the word at `colAddr` on `rdData`, with `rdValid` high for exactly the one cycle after the read command.
- R3: A write (code 4) to the open subarray updates both the row buffer and the open row's cells. The value is still there after the bank is closed and the row is opened again.
- R4: An open-row command to a different row of the subarray that is already open copies all columns of the row buffer into the new row, and the new row becomes the open row. The previous row keeps its contents.
- R5: Row 0 of each subarray always reads as zeros. A write to it is ignored. A row copy that targets it leaves it zero and reloads the row buffer with zeros.
- R6: A close (code 2) closes the bank. A read or write to a closed bank, or to a subarray of the bank that is not the open one, is rejected. Rejection means `cmdError` is high in the next cycle, `rdValid` stays low and no storage changes.
- R7: An open-row command to a different subarray of a bank that already has an open row is rejected (`cmdError` next cycle). The open row stays open and unchanged, and the other row is neither loaded nor modified.
- R8: A line transfer (code 5) copies line `colAddr/4` (columns 4·line to 4·line+3) from the open row buffer of bank `bankAddr` into the open row of bank `dstBank`, including its cells. The other columns of the destination are left unchanged. `busy` is high for exactly 5 cycles, starting in the cycle after the command.
- R9: Any non-idle command while `busy` is high is rejected. A line transfer whose source and destination bank are the same, or whose source or destination bank is closed, is also rejected. A rejected command sets `cmdError` in the next cycle and does not start `busy`.
- R10: An open-row command to the row that is already open in that subarray has no effect and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command code (see R1) |
| bankAddr | input | 1 | Target bank; source bank for a line transfer |
| subAddr | input | 1 | Subarray within the bank |
| rowAddr | input | 3 | Row within the subarray |
| colAddr | input | 3 | Column (word); selects the line for a transfer |
| dstBank | input | 1 | Destination bank of a line transfer |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| cmdError | output | 1 | Previous command was rejected |
| busy | output | 1 | Line transfer in progress |

## Verification
The bench checks the following corner cases, each with the fault it would catch:
- Row copy: the bench reads the copied data from both the buffer and the cells, and it reads the source row back. A model that copied only part of the row, or that overwrote the source, would show stale or wrong words.
- Reserved zero row: the bench writes to it and copies into it. A model without write gating would read back non-zero data.
- Rejection paths: the bench drives reads on closed banks, cross-subarray opens, self-transfers and commands issued during a transfer. Each is checked for both the error pulse and the absence of side effects, so a design that acted on an illegal command would corrupt rows or produce a spurious `rdValid`.
- Transfer window: the bench counts the `busy` cycles and reads all eight destination columns. This exposes an off-by-one line boundary and a skipped final word.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;
  localparam int BANKS      = 2;
  localparam int SUBS       = 2;
  localparam int ROWS       = 8;
  localparam int COLS       = 8;
  localparam int WORD_W     = 8;
  localparam int LINE_WORDS = 4;
  localparam int ZERO_ROW   = 0;

  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int SUB_W  = (SUBS > 1) ? $clog2(SUBS) : 1;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int CNT_W  = $clog2(LINE_WORDS + 1);

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_RD   = 3'd3,
    CMD_WR   = 3'd4,
    CMD_XFER = 3'd5
  } cmd_e;

  typedef struct packed {
    logic              load;
    logic              copy;
    logic              rd;
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [SUB_W-1:0]  sub;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [WORD_W-1:0] wrData;
    logic              xferRd;
    logic [BANK_W-1:0] srcBank;
    logic [SUB_W-1:0]  srcSub;
    logic [COL_W-1:0]  srcCol;
    logic              xferWr;
    logic [BANK_W-1:0] dstBank;
    logic [SUB_W-1:0]  dstSub;
    logic [ROW_W-1:0]  dstRow;
    logic [COL_W-1:0]  dstCol;
  } strobe_t;
endpackage

// File: rtl/rowcopy_ctrl.sv
module rowcopy_ctrl
  import rowcopy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic [SUB_W-1:0]  subAddr,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [BANK_W-1:0] dstBank,
  input  logic [WORD_W-1:0] wrData,
  output strobe_t           stb,
  output logic              cmdError,
  output logic              busy
);
  logic [BANKS-1:0] bankOpen;
  logic [SUB_W-1:0] openSub [BANKS];
  logic [ROW_W-1:0] openRow [BANKS];

  logic              xferActive;
  logic [CNT_W-1:0]  xferCnt;
  logic [BANK_W-1:0] xSrcBank, xDstBank;
  logic [SUB_W-1:0]  xSrcSub, xDstSub;
  logic [ROW_W-1:0]  xDstRow;
  logic [COL_W-1:0]  xBase;

  logic errNext, startXfer, closeBank, sameSub;
  logic [COL_W-1:0] lineBase;

  assign lineBase = colAddr & ~COL_W'(LINE_WORDS - 1);
  assign sameSub  = bankOpen[bankAddr] && (openSub[bankAddr] == subAddr);
  assign busy     = xferActive;

  always_comb begin
    stb        = '0;
    stb.bank   = bankAddr;
    stb.sub    = subAddr;
    stb.row    = rowAddr;
    stb.col    = colAddr;
    stb.wrData = wrData;
    errNext    = 1'b0;
    startXfer  = 1'b0;
    closeBank  = 1'b0;
    if (xferActive) begin
      errNext = (cmd != CMD_NOP) && (cmd <= CMD_XFER);
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (!bankOpen[bankAddr])             stb.load = 1'b1;
          else if (!sameSub)                   errNext  = 1'b1;
          else if (openRow[bankAddr] != rowAddr) stb.copy = 1'b1;
        end
        CMD_PRE: closeBank = 1'b1;
        CMD_RD: begin
          if (sameSub) stb.rd = 1'b1;
          else         errNext = 1'b1;
        end
        CMD_WR: begin
          stb.row = openRow[bankAddr];
          if (sameSub) stb.wr = 1'b1;
          else         errNext = 1'b1;
        end
        CMD_XFER: begin
          if (bankAddr != dstBank && bankOpen[bankAddr] && bankOpen[dstBank])
            startXfer = 1'b1;
          else
            errNext = 1'b1;
        end
        default: ;
      endcase
    end
    // overlapped line transfer: fetch word k while storing word k-1
    stb.xferRd  = xferActive && (xferCnt < CNT_W'(LINE_WORDS));
    stb.srcBank = xSrcBank;
    stb.srcSub  = xSrcSub;
    stb.srcCol  = xBase + COL_W'(xferCnt);
    stb.xferWr  = xferActive && (xferCnt != '0);
    stb.dstBank = xDstBank;
    stb.dstSub  = xDstSub;
    stb.dstRow  = xDstRow;
    stb.dstCol  = xBase + COL_W'(xferCnt - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankOpen   <= '0;
      for (int b = 0; b < BANKS; b++) begin
        openSub[b] <= '0;
        openRow[b] <= '0;
      end
      xferActive <= 1'b0;
      xferCnt    <= '0;
      xSrcBank   <= '0;
      xDstBank   <= '0;
      xSrcSub    <= '0;
      xDstSub    <= '0;
      xDstRow    <= '0;
      xBase      <= '0;
      cmdError   <= 1'b0;
    end else begin
      cmdError <= errNext;
      if (stb.load) begin
        bankOpen[bankAddr] <= 1'b1;
        openSub[bankAddr]  <= subAddr;
        openRow[bankAddr]  <= rowAddr;
      end
      if (stb.copy) openRow[bankAddr] <= rowAddr;
      if (closeBank) bankOpen[bankAddr] <= 1'b0;
      if (startXfer) begin
        xferActive <= 1'b1;
        xferCnt    <= '0;
        xSrcBank   <= bankAddr;
        xSrcSub    <= openSub[bankAddr];
        xDstBank   <= dstBank;
        xDstSub    <= openSub[dstBank];
        xDstRow    <= openRow[dstBank];
        xBase      <= lineBase;
      end else if (xferActive) begin
        if (xferCnt == CNT_W'(LINE_WORDS)) begin
          xferActive <= 1'b0;
          xferCnt    <= '0;
        end else begin
          xferCnt <= xferCnt + 1'b1;
        end
      end
    end
  end

  AST_ERR_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> (bankOpen == $past(bankOpen))); // R7
  AST_XFER_BANKS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |-> (bankOpen[xSrcBank] && bankOpen[xDstBank] && xSrcBank != xDstBank)); // R8
  AST_XFER_WINDOW_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && xferCnt == CNT_W'(LINE_WORDS)) |=> !xferActive); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.copy, stb.rd, stb.wr, xferActive})); // R9
endmodule

// File: rtl/rowcopy_datapath.sv
module rowcopy_datapath
  import rowcopy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  logic [WORD_W-1:0] cells  [BANKS][SUBS][ROWS][COLS];
  logic [WORD_W-1:0] rowBuf [BANKS][SUBS][COLS];
  logic [WORD_W-1:0] busReg;

  localparam logic [ROW_W-1:0] ZROW = ROW_W'(ZERO_ROW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BANKS; b++)
        for (int s = 0; s < SUBS; s++)
          for (int c = 0; c < COLS; c++) begin
            rowBuf[b][s][c] <= '0;
            for (int r = 0; r < ROWS; r++) cells[b][s][r][c] <= '0;
          end
      busReg  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rd;
      if (stb.rd) rdData <= rowBuf[stb.bank][stb.sub][stb.col];
      if (stb.load)
        for (int c = 0; c < COLS; c++)
          rowBuf[stb.bank][stb.sub][c] <= cells[stb.bank][stb.sub][stb.row][c];
      if (stb.copy) begin
        for (int c = 0; c < COLS; c++) begin
          if (stb.row == ZROW) rowBuf[stb.bank][stb.sub][c] <= '0;
          else cells[stb.bank][stb.sub][stb.row][c] <= rowBuf[stb.bank][stb.sub][c];
        end
      end
      if (stb.wr && stb.row != ZROW) begin
        rowBuf[stb.bank][stb.sub][stb.col]         <= stb.wrData;
        cells[stb.bank][stb.sub][stb.row][stb.col] <= stb.wrData;
      end
      if (stb.xferRd) busReg <= rowBuf[stb.srcBank][stb.srcSub][stb.srcCol];
      if (stb.xferWr && stb.dstRow != ZROW) begin
        rowBuf[stb.dstBank][stb.dstSub][stb.dstCol]             <= busReg;
        cells[stb.dstBank][stb.dstSub][stb.dstRow][stb.dstCol] <= busReg;
      end
    end
  end

  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
    for (genvar gs = 0; gs < SUBS; gs++) begin : g_sub
      for (genvar gc = 0; gc < COLS; gc++) begin : g_col
        AST_ZERO_ROW_HELD: assert property (@(posedge clk) disable iff (!rstN)
          cells[gb][gs][ZERO_ROW][gc] == '0); // R5
      end
    end
  end
endmodule

// File: rtl/rowcopy_top.sv
module rowcopy_top
  import rowcopy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic [SUB_W-1:0]  subAddr,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [BANK_W-1:0] dstBank,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              cmdError,
  output logic              busy
);
  strobe_t stb;

  rowcopy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankAddr(bankAddr), .subAddr(subAddr),
    .rowAddr(rowAddr), .colAddr(colAddr), .dstBank(dstBank), .wrData(wrData),
    .stb(stb), .cmdError(cmdError), .busy(busy)
  );

  rowcopy_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/rowcopy_top_bench.sv
module rowcopy_top_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] cmd;
  logic       bankAddr, subAddr, dstBank;
  logic [2:0] rowAddr, colAddr;
  logic [7:0] wrData, rdData;
  logic       rdValid, cmdError, busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rowcopy_top u_rowcopy_top (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankAddr(bankAddr), .subAddr(subAddr),
    .rowAddr(rowAddr), .colAddr(colAddr), .dstBank(dstBank), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .cmdError(cmdError), .busy(busy)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] c;
    logic       b;
    logic       s;
    logic [2:0] r;
    logic [2:0] col;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] exp;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2, 3'd1, 1'b0, 1'b0, 3'd1, 3'd0, 8'h00, 1'b0, 8'h00}, // R2 open b0 s0 r1
    '{4'd3, 3'd4, 1'b0, 1'b0, 3'd0, 3'd0, 8'h11, 1'b0, 8'h00}, // R3 write
    '{4'd3, 3'd4, 1'b0, 1'b0, 3'd0, 3'd3, 8'h33, 1'b0, 8'h00}, // R3
    '{4'd3, 3'd4, 1'b0, 1'b0, 3'd0, 3'd7, 8'h77, 1'b0, 8'h00}, // R3
    '{4'd2, 3'd3, 1'b0, 1'b0, 3'd0, 3'd3, 8'h00, 1'b1, 8'h33}, // R2 read
    '{4'd6, 3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00}, // R6 close
    '{4'd3, 3'd1, 1'b0, 1'b0, 3'd1, 3'd0, 8'h00, 1'b0, 8'h00}, // R3 reopen
    '{4'd3, 3'd3, 1'b0, 1'b0, 3'd0, 3'd7, 8'h00, 1'b1, 8'h77}, // R3 persisted
    '{4'd4, 3'd1, 1'b0, 1'b0, 3'd2, 3'd0, 8'h00, 1'b0, 8'h00}, // R4 copy r1->r2
    '{4'd4, 3'd3, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 8'h11}, // R4
    '{4'd4, 3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00}, // R4
    '{4'd4, 3'd1, 1'b0, 1'b0, 3'd2, 3'd0, 8'h00, 1'b0, 8'h00}, // R4 reopen r2
    '{4'd4, 3'd3, 1'b0, 1'b0, 3'd0, 3'd3, 8'h00, 1'b1, 8'h33}, // R4 cells
    '{4'd4, 3'd3, 1'b0, 1'b0, 3'd0, 3'd7, 8'h00, 1'b1, 8'h77}, // R4 whole row
    '{4'd4, 3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00}, // R4
    '{4'd4, 3'd1, 1'b0, 1'b0, 3'd1, 3'd0, 8'h00, 1'b0, 8'h00}, // R4 source
    '{4'd4, 3'd3, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 8'h11}, // R4 source kept
    '{4'd2, 3'd1, 1'b1, 1'b1, 3'd5, 3'd0, 8'h00, 1'b0, 8'h00}, // R2 bank1
    '{4'd3, 3'd4, 1'b1, 1'b1, 3'd0, 3'd4, 8'hA4, 1'b0, 8'h00}, // R3
    '{4'd2, 3'd3, 1'b1, 1'b1, 3'd0, 3'd4, 8'h00, 1'b1, 8'hA4}  // R2
  };

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] c, logic b, logic s, logic [2:0] r,
                       logic [2:0] col, logic d, logic [7:0] wd);
    cmd = c; bankAddr = b; subAddr = s; rowAddr = r; colAddr = col;
    dstBank = d; wrData = wd;
  endtask

  // one command, then idle; returns at the negedge after the command edge
  task automatic issue(logic [2:0] c, logic b, logic s, logic [2:0] r,
                       logic [2:0] col, logic d, logic [7:0] wd);
    @(negedge clk); drive(c, b, s, r, col, d, wd);
    @(negedge clk); drive(3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
  endtask

  task automatic readExpect(string tag, logic b, logic s, logic [2:0] col, logic [7:0] exp);
    issue(3'd3, b, s, 3'd0, col, 1'b0, 8'h00);
    check(tag, {cmdError, rdValid, rdData}, {1'b0, 1'b1, exp});
  endtask

  task automatic expectReject(string tag);
    check(tag, {cmdError, rdValid, busy}, {1'b1, 1'b0, 1'b0});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    drive(3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int busyCnt;
    doReset();
    // R1 reset state
    check("R1 outputs", {rdValid, cmdError, busy}, 3'b000);
    issue(3'd1, 1'b0, 1'b1, 3'd3, 3'd0, 1'b0, 8'h00);
    readExpect("R1 cells zero", 1'b0, 1'b1, 3'd2, 8'h00);
    issue(3'd7, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    check("R1 unused code idle", {cmdError, rdValid}, 2'b00);

    // vector table
    doReset();
    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].c, VECS[i].b, VECS[i].s, VECS[i].r, VECS[i].col, 1'b0, VECS[i].wd);
      checks++;
      if (cmdError !== 1'b0 || rdValid !== VECS[i].chk ||
          (VECS[i].chk && rdData !== VECS[i].exp)) begin
        errors++;
        $display("FAIL R%0d vec %0d: actual=err%0b val%0b %0h expected=err0 val%0b %0h",
                 VECS[i].req, i, cmdError, rdValid, rdData, VECS[i].chk, VECS[i].exp);
      end
    end
    @(negedge clk);
    check("R2 single-cycle valid", rdValid, 1'b0);

    // R5 reserved zero row
    doReset();
    issue(3'd1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd4, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 8'h5A);
    readExpect("R5 write ignored", 1'b0, 1'b0, 3'd1, 8'h00);
    issue(3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd1, 1'b0, 1'b0, 3'd4, 3'd0, 1'b0, 8'h00);
    issue(3'd4, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 8'h5A);
    issue(3'd1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    readExpect("R5 copy into zero row buffer", 1'b0, 1'b0, 3'd1, 8'h00);
    issue(3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    readExpect("R5 zero row cells", 1'b0, 1'b0, 3'd1, 8'h00);
    issue(3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd1, 1'b0, 1'b0, 3'd4, 3'd0, 1'b0, 8'h00);
    readExpect("R5 source row kept", 1'b0, 1'b0, 3'd1, 8'h5A);

    // R6 closed bank / wrong subarray
    doReset();
    issue(3'd3, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    expectReject("R6 read closed");
    issue(3'd4, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'hEE);
    expectReject("R6 write closed");
    issue(3'd1, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 8'h00);
    issue(3'd4, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 8'h63);
    issue(3'd2, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd3, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 8'h00);
    expectReject("R6 read after close");
    issue(3'd1, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h00);
    readExpect("R6 rejected write no effect", 1'b1, 1'b0, 3'd0, 8'h00);
    issue(3'd4, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h42);
    issue(3'd3, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 8'h00);
    expectReject("R6 read other subarray");

    // R7 cross-subarray open
    issue(3'd1, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 8'h00);
    expectReject("R7 cross-subarray open");
    readExpect("R7 open row kept", 1'b1, 1'b0, 3'd0, 8'h42);
    issue(3'd2, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd1, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 8'h00);
    readExpect("R7 other row untouched", 1'b1, 1'b1, 3'd0, 8'h63);

    // R10 reopen of the same row
    issue(3'd4, 1'b1, 1'b1, 3'd0, 3'd1, 1'b0, 8'h71);
    issue(3'd1, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 8'h00);
    check("R10 no error", cmdError, 1'b0);
    readExpect("R10 buffer kept", 1'b1, 1'b1, 3'd1, 8'h71);

    // R8 line transfer
    doReset();
    issue(3'd1, 1'b0, 1'b1, 3'd6, 3'd0, 1'b0, 8'h00);
    for (int c = 0; c < 8; c++) issue(3'd4, 1'b0, 1'b1, 3'd0, 3'(c), 1'b0, 8'hC0 + 8'(c));
    issue(3'd1, 1'b1, 1'b0, 3'd5, 3'd0, 1'b0, 8'h00);
    for (int c = 0; c < 8; c++) issue(3'd4, 1'b1, 1'b0, 3'd0, 3'(c), 1'b0, 8'hD0 + 8'(c));
    @(negedge clk); drive(3'd5, 1'b0, 1'b0, 3'd0, 3'd5, 1'b1, 8'h00);
    @(negedge clk); drive(3'd3, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    check("R8 busy after command", {busy, cmdError}, 2'b10);
    busyCnt = 1;
    @(negedge clk); drive(3'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    check("R9 command during busy", {cmdError, rdValid}, 2'b10);
    while (busy && busyCnt < 20) begin
      busyCnt++;
      @(negedge clk);
    end
    check("R8 busy length", busyCnt, 5);
    for (int c = 0; c < 8; c++)
      readExpect("R8 destination word", 1'b1, 1'b0, 3'(c),
                 (c < 4) ? 8'hD0 + 8'(c) : 8'hC0 + 8'(c));
    readExpect("R8 source unchanged", 1'b0, 1'b1, 3'd4, 8'hC4);
    issue(3'd2, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd1, 1'b1, 1'b0, 3'd5, 3'd0, 1'b0, 8'h00);
    readExpect("R8 destination cells", 1'b1, 1'b0, 3'd6, 8'hC6);

    // R9 illegal transfers
    issue(3'd5, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    expectReject("R9 same bank transfer");
    issue(3'd2, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 8'h00);
    issue(3'd5, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 8'h00);
    expectReject("R9 closed destination");
    finishRun();
  end
endmodule